// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits between the instruction memory and the instruction latch of a small stack processor. Each 18-bit instruction word holds three 5-bit opcode slots. The block hands those slots to the latch one at a time, starting with the most significant slot. A one-cycle ready strobe from the memory side delivers a word and latches its first slot at once. Each later slot follows after a fixed gap, given as a parameter in clock cycles. This stands in for a delayed repeat of the ready pulse.

A word is finished when its third slot has been issued. It is also finished early when the slot just issued is a branch, a call or a memory access opcode, because execution then cannot continue inside the same word. When a word finishes, the block raises a one-cycle request for the next word and waits for the next ready strobe. A ready strobe that arrives while a word is still being issued abandons the rest of that word and starts the new one at its first slot.

Top module: `packed_slot_sequencer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `op_o` is 0 and `issue_o` and `fetch_req_o` are low.
- R2: A cycle with `ready_i` high is followed in the next cycle by `issue_o` high with `op_o` equal to `word_i[17:13]` of the strobe cycle.
- R3: If the issued slot does not end the word, the next slot is issued exactly `GAP_CYCLES` cycles later. The second slot is taken from word bits 12:8 and the third from bits 7:3.
- R4: Word bits 2:0 have no effect on any output.
- R5: `fetch_req_o` is high for exactly one cycle, in the same cycle as the issue of the slot that ends the word. After that, nothing more is issued until the next ready strobe.
- R6: An opcode ends the word early when its bit 4 is 0 and bits 3:2 are not 01, which covers the values 0 to 3 and 8 to 15. The values 4 to 7 and 16 to 31 do not end the word. Issuing the third slot ends the word whatever its value.
- R7: A ready strobe during an unfinished word restarts issuing at the first slot of the new word. No remaining slot of the old word is issued.
- R8: `op_o` keeps its value in every cycle in which `issue_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | One-cycle strobe: a new instruction word is on `word_i` |
| word_i | input | 18 | Packed instruction word, first slot in the top bits |
| op_o | output | 5 | Opcode held in the instruction latch |
| issue_o | output | 1 | High in the cycle a new opcode appears on `op_o` |
| fetch_req_o | output | 1 | One-cycle request for the next instruction word |

## Verification
Some properties are checked on every cycle by assertions. The slot selector stays one-hot or idle. A ready strobe always yields an issue of the top slot in the next cycle. An end-of-word opcode is always issued together with a fetch request. No issue follows a finished word without a new strobe. The latched opcode stays steady between issues. The gap timer cannot report expiry right after a reload. Other behaviours need the bench's scenarios and its cycle-by-cycle reference model: the exact spacing between slots, the bit fields each slot comes from, early ending at the first or second slot, restarts in mid-word and back-to-back strobes, and the fact that the low three bits do nothing.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int OPC_W = 5;

    // Opcodes that leave the word: jumps, calls, conditional branches
    // (0..3) and memory fetch/store (8..15). Values 4..7 stay in the word.
    function automatic logic ends_word(input logic [OPC_W-1:0] op);
        return (op[4] == 1'b0) && (op[3:2] != 2'b01);
    endfunction

endpackage

// File: rtl/pss_slot_mux.sv
module pss_slot_mux #(
    parameter int WORD_W  = 18,
    parameter int N_SLOTS = 3,
    parameter int OP_W    = 5
) (
    input  logic [WORD_W-1:0]  word_i,
    input  logic [N_SLOTS-1:0] sel_i,
    output logic [OP_W-1:0]    op_o
);

    logic [N_SLOTS-1:0][OP_W-1:0] field;

    generate
        for (genvar i = 0; i < N_SLOTS; i++) begin : g_field
            assign field[i] = word_i[WORD_W-1-i*OP_W -: OP_W];
        end
    endgenerate

    always_comb begin
        op_o = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (sel_i[i]) begin
                op_o = op_o | field[i];
            end
        end
    end

endmodule

// File: rtl/pss_gap_timer.sv
module pss_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = RELOAD;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    generate
        if (GAP > 1) begin : g_chk
            AST_GAP_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
                load_i |=> !expired_o); // R3
        end
    endgenerate

endmodule

// File: rtl/packed_slot_sequencer.sv
module packed_slot_sequencer #(
    parameter int WORD_W     = 18,
    parameter int N_SLOTS    = 3,
    parameter int GAP_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [4:0]        op_o,
    output logic              issue_o,
    output logic              fetch_req_o
);

    import pss_pkg::*;

    localparam logic [N_SLOTS-1:0] FIRST_SEL = N_SLOTS'(1);

    typedef struct packed {
        logic [WORD_W-1:0]  word;
        logic [N_SLOTS-1:0] sel;
        logic [OPC_W-1:0]   op;
        logic               issue;
        logic               req;
    } state_t;

    state_t s_d, s_q;

    logic               active;
    logic               gap_done;
    logic               step;
    logic               last;
    logic               load_gap;
    logic [WORD_W-1:0]  pick_word;
    logic [N_SLOTS-1:0] pick_sel;
    logic [OPC_W-1:0]   picked_op;

    assign active = |s_q.sel;

    // Source of the next slot: a fresh word wins over the one in progress.
    always_comb begin
        if (ready_i) begin
            pick_word = word_i;
            pick_sel  = FIRST_SEL;
        end else begin
            pick_word = s_q.word;
            pick_sel  = s_q.sel << 1;
        end
    end

    pss_slot_mux #(
        .WORD_W  (WORD_W),
        .N_SLOTS (N_SLOTS),
        .OP_W    (OPC_W)
    ) u_mux (
        .word_i (pick_word),
        .sel_i  (pick_sel),
        .op_o   (picked_op)
    );

    pss_gap_timer #(
        .GAP (GAP_CYCLES)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_gap),
        .run_i     (active),
        .expired_o (gap_done)
    );

    assign step     = ready_i || (active && gap_done);
    assign last     = pick_sel[N_SLOTS-1] || ends_word(picked_op);
    assign load_gap = step && !last;

    always_comb begin
        s_d       = s_q;
        s_d.issue = 1'b0;
        s_d.req   = 1'b0;
        if (step) begin
            s_d.word  = pick_word;
            s_d.op    = picked_op;
            s_d.issue = 1'b1;
            if (last) begin
                s_d.sel = '0;
                s_d.req = 1'b1;
            end else begin
                s_d.sel = pick_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_o        = s_q.op;
    assign issue_o     = s_q.issue;
    assign fetch_req_o = s_q.req;

    AST_READY_ISSUES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> issue_o && (op_o == $past(word_i[WORD_W-1 -: OPC_W]))); // R2
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.sel)); // R3
    AST_REQ_WITH_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o |-> issue_o); // R5
    AST_IDLE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req_o && !ready_i |=> !issue_o); // R5
    AST_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o && ends_word(op_o) |-> fetch_req_o); // R6
    AST_OP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_o |-> $stable(op_o)); // R8

endmodule

// File: tb/packed_slot_sequencer_bench.sv
module packed_slot_sequencer_bench;

    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ready_i = 1'b0;
    logic [17:0] word_i = '0;
    logic [4:0]  op_o;
    logic        issue_o;
    logic        fetch_req_o;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    string tag = "R1";

    // behavioural reference state
    int        m_slot = -1;
    int        m_wait = 0;
    int        m_word = 0;
    int        e_op = 0;
    bit        e_issue = 1'b0;
    bit        e_req = 1'b0;

    always #2.5 clk = ~clk;

    packed_slot_sequencer #(
        .WORD_W     (18),
        .N_SLOTS    (3),
        .GAP_CYCLES (GAP)
    ) u_packed_slot_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready_i),
        .word_i      (word_i),
        .op_o        (op_o),
        .issue_o     (issue_o),
        .fetch_req_o (fetch_req_o)
    );

    function automatic int slot_of(input int w, input int k);
        return (w >> (13 - 5 * k)) & 31;
    endfunction

    function automatic bit leaves(input int op);
        return (op < 4) || (op >= 8 && op < 16);
    endfunction

    function automatic logic [17:0] mk(input int a, input int b, input int c, input int lo);
        return {a[4:0], b[4:0], c[4:0], lo[2:0]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_slot = -1; m_wait = 0; e_op = 0; e_issue = 0; e_req = 0;
        end else begin
            e_issue = 0;
            e_req = 0;
            if (ready_i) begin
                m_word = int'(word_i);
                m_slot = 0;
                e_op = slot_of(m_word, 0);
                e_issue = 1;
                if (leaves(e_op)) begin m_slot = -1; e_req = 1; end
                else m_wait = GAP - 1;
            end else if (m_slot >= 0) begin
                if (m_wait == 0) begin
                    m_slot++;
                    e_op = slot_of(m_word, m_slot);
                    e_issue = 1;
                    if (m_slot == 2 || leaves(e_op)) begin m_slot = -1; e_req = 1; end
                    else m_wait = GAP - 1;
                end else begin
                    m_wait--;
                end
            end
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check(op_o == 5'(e_op), "op_o", int'(op_o), e_op);
            check(issue_o == e_issue, "issue_o", int'(issue_o), int'(e_issue));
            check(fetch_req_o == e_req, "fetch_req_o", int'(fetch_req_o), int'(e_req));
        end
    end

    task automatic send(input logic [17:0] w);
        @(negedge clk);
        ready_i = 1'b1;
        word_i  = w;
        @(negedge clk);
        ready_i = 1'b0;
        word_i  = 18'h2aaaa;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tag = "R1";
        idle(2);
        check(op_o == 0 && !issue_o && !fetch_req_o, "outputs in reset", int'(op_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        check(op_o == 0 && !issue_o && !fetch_req_o, "outputs after reset", int'(op_o), 0);
        cmp_on = 1'b1;

        // R2/R3/R5: full word of non-ending opcodes, slots GAP apart
        tag = "R3";
        send(mk(5'h1e, 5'h10, 5'h17, 0));
        idle(12);
        // R4: same word with different low bits
        tag = "R4";
        send(mk(5'h1e, 5'h10, 5'h17, 7));
        idle(12);
        // R6: first slot is a call
        tag = "R6";
        send(mk(5'h02, 5'h1e, 5'h1e, 0));
        idle(10);
        // R6: second slot is a fetch
        send(mk(5'h1e, 5'h09, 5'h1e, 3));
        idle(10);
        // R6: values 4..7 do not end the word
        send(mk(5'h06, 5'h04, 5'h1c, 0));
        idle(12);
        // R6: last slot an ending opcode, boundary 15
        send(mk(5'h07, 5'h10, 5'h0f, 0));
        idle(12);
        // R7: restart mid-word
        tag = "R7";
        send(mk(5'h1e, 5'h1d, 5'h1c, 0));
        idle(2);
        send(mk(5'h11, 5'h12, 5'h13, 5));
        idle(12);
        // R2: back-to-back strobes
        tag = "R2";
        @(negedge clk);
        ready_i = 1'b1; word_i = mk(5'h14, 5'h15, 5'h16, 0);
        @(negedge clk);
        word_i = mk(5'h18, 5'h19, 5'h1a, 1);
        @(negedge clk);
        word_i = mk(5'h00, 5'h19, 5'h1a, 2);
        @(negedge clk);
        ready_i = 1'b0;
        idle(12);
        // R8 and R5: long idle, latch holds, no requests
        tag = "R8";
        idle(20);
        cmp_on = 1'b0;
        finish_run();
    end

endmodule